// File: doc/BRIEF.md
# Windowed DMA Address Generator

This block produces the byte addresses for one DMA channel, one stream for the source side and one for the destination side. Software-facing setup is reduced to a handful of values. These are the transfer direction, a device address and a memory address, the size of the device's data-port window, the element size, the number of elements in a frame and the number of frames. A decoder derives from them an addressing mode, an element index and a frame index for each side. It also derives a burst-length code for each side and a write-posting tag. All of these are latched when a start pulse arrives while the block is idle.

Each side runs in one of three modes. In constant mode the address never changes. In post-increment mode the address grows by the element size after each element. In double-indexed mode the element index is applied inside a frame and a signed frame index is applied at each frame boundary. When a window is configured, the device side runs double-indexed with an element index of 1 and a frame index of −(window − 1). The device address therefore sweeps the window once per frame and jumps back to the window start, while the memory side keeps incrementing linearly. Without a window, the device side stays on a constant address.

After a start, the block offers one address pair per valid/ready handshake. It flags the last element of every frame and the last element of the whole transfer, and it tells the consumer whether the current write must be non-posted. One cycle after the final handshake it pulses `done` and returns to idle.

Top module: `wdag_top`

## Requirements
- R1: After reset `busy`, `out_valid` and `done` are 0.
- R2: A `start` pulse while idle latches all configuration inputs. From the next cycle `busy` and `out_valid` are 1, and the first address pair is the configured source and destination base. A `start` while busy is ignored: the running sequence and its latched configuration are unchanged, even if the configuration inputs change meanwhile.
- R3: With `win_bytes` = 0 the device-side address stays equal to `dev_addr` for the whole transfer (constant mode).
- R4: The memory-side address advances by the element size (1 << `elem_log2` bytes) on every handshake, without interruption across frame boundaries (post-increment mode).
- R5: With `win_bytes` = W ≠ 0 the device side is double-indexed with element index 1 and frame index −(W − 1). The address step is (esize + EI − 1) inside a frame and (esize + FI − 1) at a frame boundary, in 32-bit two's-complement arithmetic. With elements_per_frame × esize = W, element e of every frame is therefore at `dev_addr` + e·esize.
- R6: `dir` = 0 (device to memory) puts the device stream on `src_addr` and the memory stream on `dst_addr`. `dir` = 1 (memory to device) swaps them.
- R7: The burst codes are 0 = none, 1 = 16 B, 2 = 32 B and 3 = 64 B. The device side gets 3 if W is a non-zero multiple of 64, else 2 if it is a multiple of 32, else 1 if it is a multiple of 16, else 0. The memory side always gets 3.
- R8: `post_mode` uses 0 = non-posted, 1 = posted and 2 = posted except the last write. It is 2 for a windowed transfer with `dir` = 1 and 0 otherwise. `write_nonposted` is 1 on every valid element in mode 0, and only on the final element in mode 2.
- R9: `frame_last` marks the last element of each frame and `xfer_last` the last element of the transfer. A transfer has exactly elements_per_frame × frame_count handshakes, and a count of 0 is treated as 1.
- R10: `done` is a one-cycle pulse in the cycle after the final handshake, and `busy` and `out_valid` are 0 in that same cycle.
- R11: While `out_valid` is 1 and `out_ready` is 0, the addresses and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and begin (idle only) |
| dir | input | 1 | 0 device to memory, 1 memory to device |
| dev_addr | input | 32 | Device (window) base byte address |
| mem_addr | input | 32 | Memory buffer base byte address |
| win_bytes | input | WIN_W | Port window size in bytes, 0 = no window |
| elem_log2 | input | 2 | Element size as log2 of bytes |
| elems_per_frame | input | CNT_W | Elements per frame (0 treated as 1) |
| frame_count | input | CNT_W | Frames per transfer (0 treated as 1) |
| out_ready | input | 1 | Consumer accepts the current address pair |
| out_valid | output | 1 | Address pair valid |
| src_addr | output | 32 | Source byte address |
| dst_addr | output | 32 | Destination byte address |
| frame_last | output | 1 | Current element ends a frame |
| xfer_last | output | 1 | Current element ends the transfer |
| write_nonposted | output | 1 | Current write must be non-posted |
| src_burst | output | 2 | Source burst code |
| dst_burst | output | 2 | Destination burst code |
| post_mode | output | 2 | Write-posting mode tag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong frame index or a missed frame-end step shows on the device address at the first element of the second frame. That is one window's worth of handshakes after start, and a mismatch there is a wrong rewind. A corrupted element counter moves `frame_last` and the rewind point together, so it is visible at the end of the first frame. A corrupted frame counter is visible at `xfer_last` and `done`. Every handshake compares both addresses and all flags against arithmetic expectations, and stall cycles compare them again, so any state error surfaces on the first element it touches.

// File: rtl/wdag_pkg.sv
package wdag_pkg;

    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        AM_CONST   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_DBLIDX  = 2'd2
    } amode_e;

    typedef enum logic [1:0] {
        BL_NONE = 2'd0,
        BL_16   = 2'd1,
        BL_32   = 2'd2,
        BL_64   = 2'd3
    } burst_e;

    typedef enum logic [1:0] {
        WP_NONPOSTED = 2'd0,
        WP_POSTED    = 2'd1,
        WP_LAST_NP   = 2'd2
    } wpost_e;

    typedef struct packed {
        amode_e mode;
        addr_t  base;
        addr_t  ei;
        addr_t  fi;
    } side_cfg_t;

    // Next address after one element; ei/fi are signed two's-complement.
    function automatic addr_t step_addr(amode_e m, addr_t a, addr_t esz,
                                        addr_t ei, addr_t fi, logic fend);
        addr_t r;
        case (m)
            AM_POSTINC: r = a + esz;
            AM_DBLIDX:  r = fend ? (a + esz + fi - addr_t'(1))
                                 : (a + esz + ei - addr_t'(1));
            default:    r = a;
        endcase
        return r;
    endfunction

    // Largest burst whose size divides the window.
    function automatic burst_e pick_burst(addr_t win);
        burst_e b;
        if (win == '0)              b = BL_NONE;
        else if (win[5:0] == 6'd0)  b = BL_64;
        else if (win[4:0] == 5'd0)  b = BL_32;
        else if (win[3:0] == 4'd0)  b = BL_16;
        else                        b = BL_NONE;
        return b;
    endfunction

endpackage

// File: rtl/wdag_cfg_decode.sv
module wdag_cfg_decode
    import wdag_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             dir,
    input  addr_t            dev_addr,
    input  addr_t            mem_addr,
    input  logic [WIN_W-1:0] win_bytes,
    output side_cfg_t        src_cfg,
    output side_cfg_t        dst_cfg,
    output burst_e           src_burst,
    output burst_e           dst_burst,
    output wpost_e           post
);

    addr_t     win_ext;
    logic      windowed;
    side_cfg_t dev_cfg;
    side_cfg_t mem_cfg;
    burst_e    dev_burst;

    assign win_ext  = addr_t'(win_bytes);
    assign windowed = (win_bytes != '0);

    always_comb begin
        dev_cfg.mode = windowed ? AM_DBLIDX : AM_CONST;
        dev_cfg.base = dev_addr;
        dev_cfg.ei   = addr_t'(1);
        dev_cfg.fi   = addr_t'(1) - win_ext;   // -(W-1)

        mem_cfg.mode = AM_POSTINC;
        mem_cfg.base = mem_addr;
        mem_cfg.ei   = addr_t'(1);
        mem_cfg.fi   = addr_t'(1);

        dev_burst    = pick_burst(win_ext);
    end

    always_comb begin
        if (dir) begin
            src_cfg   = mem_cfg;
            dst_cfg   = dev_cfg;
            src_burst = BL_64;
            dst_burst = dev_burst;
        end else begin
            src_cfg   = dev_cfg;
            dst_cfg   = mem_cfg;
            src_burst = dev_burst;
            dst_burst = BL_64;
        end
        post = (windowed && dir) ? WP_LAST_NP : WP_NONPOSTED;
    end

endmodule

// File: rtl/wdag_seq.sv
module wdag_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] elem_cnt,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             ready,
    output logic             busy,
    output logic             load,
    output logic             step,
    output logic             frame_end,
    output logic             xfer_end,
    output logic             done
);

    logic [CNT_W-1:0] elem_lim_q, frame_lim_q;
    logic [CNT_W-1:0] elem_q, frame_q;

    assign load      = start && !busy;
    assign step      = busy && ready;
    assign frame_end = (elem_q == elem_lim_q);
    assign xfer_end  = frame_end && (frame_q == frame_lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            elem_q      <= '0;
            frame_q     <= '0;
            elem_lim_q  <= '0;
            frame_lim_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy        <= 1'b1;
                elem_q      <= '0;
                frame_q     <= '0;
                elem_lim_q  <= (elem_cnt  == '0) ? '0 : elem_cnt  - 1'b1;
                frame_lim_q <= (frame_cnt == '0) ? '0 : frame_cnt - 1'b1;
            end else if (step) begin
                if (frame_end) begin
                    elem_q <= '0;
                    if (xfer_end) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        frame_q <= frame_q + 1'b1;
                    end
                end else begin
                    elem_q <= elem_q + 1'b1;
                end
            end
        end
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (step && xfer_end) |=> (done && !busy));                           // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R10
    AST_ELEM_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (elem_q <= elem_lim_q && frame_q <= frame_lim_q));        // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(step && xfer_end)) |=> busy);                  // R2

endmodule

// File: rtl/wdag_addr_side.sv
module wdag_addr_side
    import wdag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      busy,
    input  logic      load,
    input  side_cfg_t cfg_in,
    input  addr_t     esz,
    input  logic      step,
    input  logic      fend,
    output addr_t     addr
);

    side_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            addr  <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
            addr  <= cfg_in.base;
        end else if (step) begin
            addr  <= step_addr(cfg_q.mode, addr, esz, cfg_q.ei, cfg_q.fi, fend);
        end
    end

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> $stable(addr));                                // R11
    AST_CONST_FIXED: assert property (@(posedge clk) disable iff (rst)
        (busy && step && cfg_q.mode == AM_CONST) |=> (addr == cfg_q.base)); // R3
    AST_POSTINC_ADV: assert property (@(posedge clk) disable iff (rst)
        (busy && step && cfg_q.mode == AM_POSTINC)
        |=> (addr == $past(addr) + $past(esz)));                           // R4

endmodule

// File: rtl/wdag_top.sv
module wdag_top
    import wdag_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir,
    input  logic [31:0]       dev_addr,
    input  logic [31:0]       mem_addr,
    input  logic [WIN_W-1:0]  win_bytes,
    input  logic [1:0]        elem_log2,
    input  logic [CNT_W-1:0]  elems_per_frame,
    input  logic [CNT_W-1:0]  frame_count,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [31:0]       src_addr,
    output logic [31:0]       dst_addr,
    output logic              frame_last,
    output logic              xfer_last,
    output logic              write_nonposted,
    output logic [1:0]        src_burst,
    output logic [1:0]        dst_burst,
    output logic [1:0]        post_mode,
    output logic              busy,
    output logic              done
);

    localparam int NSIDE = 2;

    side_cfg_t dec_src, dec_dst;
    burst_e    dec_src_b, dec_dst_b;
    wpost_e    dec_post;

    burst_e    src_b_q, dst_b_q;
    wpost_e    post_q;
    addr_t     esz_q;
    logic      dir_q;
    logic      win_q;
    logic      win_fit_q;
    addr_t     dev_base_q;

    logic load, step, frame_end, xfer_end;

    side_cfg_t side_cfg  [NSIDE];
    addr_t     side_addr [NSIDE];

    wdag_cfg_decode #(.WIN_W(WIN_W)) u_dec (
        .dir       (dir),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .win_bytes (win_bytes),
        .src_cfg   (dec_src),
        .dst_cfg   (dec_dst),
        .src_burst (dec_src_b),
        .dst_burst (dec_dst_b),
        .post      (dec_post)
    );

    wdag_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .elem_cnt  (elems_per_frame),
        .frame_cnt (frame_count),
        .ready     (out_ready),
        .busy      (busy),
        .load      (load),
        .step      (step),
        .frame_end (frame_end),
        .xfer_end  (xfer_end),
        .done      (done)
    );

    assign side_cfg[0] = dec_src;
    assign side_cfg[1] = dec_dst;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        wdag_addr_side u_side (
            .clk    (clk),
            .rst    (rst),
            .busy   (busy),
            .load   (load),
            .cfg_in (side_cfg[s]),
            .esz    (esz_q),
            .step   (step),
            .fend   (frame_end),
            .addr   (side_addr[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_b_q    <= BL_NONE;
            dst_b_q    <= BL_NONE;
            post_q     <= WP_NONPOSTED;
            esz_q      <= addr_t'(1);
            dir_q      <= 1'b0;
            win_q      <= 1'b0;
            win_fit_q  <= 1'b0;
            dev_base_q <= '0;
        end else if (load) begin
            src_b_q    <= dec_src_b;
            dst_b_q    <= dec_dst_b;
            post_q     <= dec_post;
            esz_q      <= addr_t'(1) << elem_log2;
            dir_q      <= dir;
            win_q      <= (win_bytes != '0);
            win_fit_q  <= ((addr_t'((elems_per_frame == '0) ? CNT_W'(1) : elems_per_frame)
                            << elem_log2) == addr_t'(win_bytes));
            dev_base_q <= dev_addr;
        end
    end

    assign out_valid  = busy;
    assign src_addr   = side_addr[0];
    assign dst_addr   = side_addr[1];
    assign frame_last = busy && frame_end;
    assign xfer_last  = busy && xfer_end;
    assign src_burst  = src_b_q;
    assign dst_burst  = dst_b_q;
    assign post_mode  = post_q;

    always_comb begin
        case (post_q)
            WP_NONPOSTED: write_nonposted = busy;
            WP_LAST_NP:   write_nonposted = busy && xfer_end;
            default:      write_nonposted = 1'b0;
        endcase
    end

    logic [31:0] dev_side_addr;
    assign dev_side_addr = dir_q ? dst_addr : src_addr;

    AST_WIN_REWIND: assert property (@(posedge clk) disable iff (rst)
        (busy && win_q && win_fit_q && step && frame_end && !xfer_end)
        |=> (dev_side_addr == dev_base_q));                                // R5
    AST_POST_LEGAL: assert property (@(posedge clk) disable iff (rst)
        post_mode != 2'd3);                                                // R8
    AST_FLAGS_ORDER: assert property (@(posedge clk) disable iff (rst)
        xfer_last |-> frame_last);                                         // R9

endmodule

// File: tb/sim_wdag_top.sv
`timescale 1ns/1ps
module sim_wdag_top;

    localparam int CNT_W = 16;
    localparam int WIN_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              dir = 1'b0;
    logic [31:0]       dev_addr = '0;
    logic [31:0]       mem_addr = '0;
    logic [WIN_W-1:0]  win_bytes = '0;
    logic [1:0]        elem_log2 = '0;
    logic [CNT_W-1:0]  elems_per_frame = '0;
    logic [CNT_W-1:0]  frame_count = '0;
    logic              out_ready = 1'b0;
    logic              out_valid;
    logic [31:0]       src_addr, dst_addr;
    logic              frame_last, xfer_last, write_nonposted;
    logic [1:0]        src_burst, dst_burst, post_mode;
    logic              busy, done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    wdag_top #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .dir(dir),
        .dev_addr(dev_addr), .mem_addr(mem_addr), .win_bytes(win_bytes),
        .elem_log2(elem_log2), .elems_per_frame(elems_per_frame),
        .frame_count(frame_count), .out_ready(out_ready),
        .out_valid(out_valid), .src_addr(src_addr), .dst_addr(dst_addr),
        .frame_last(frame_last), .xfer_last(xfer_last),
        .write_nonposted(write_nonposted), .src_burst(src_burst),
        .dst_burst(dst_burst), .post_mode(post_mode), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_burst(input int w);
        if (w == 0)           return 2'd0;
        else if (w % 64 == 0) return 2'd3;
        else if (w % 32 == 0) return 2'd2;
        else if (w % 16 == 0) return 2'd1;
        else                  return 2'd0;
    endfunction

    task automatic run_case(input bit d, input int w, input int el,
                            input int en, input int fn);
        logic [31:0] dbase, mbase, edev, emem, esrc, edst;
        int esz, en_e, fn_e, k, e, f;
        logic [1:0] epost;
        bit elast, flast, enp;
        dbase = 32'h4000_0000 + 32'(w * 256 + el * 16);
        mbase = 32'h8000_1000 + 32'(en * 4);
        esz   = 1 << el;
        en_e  = (en == 0) ? 1 : en;
        fn_e  = (fn == 0) ? 1 : fn;
        epost = (w != 0 && d) ? 2'd2 : 2'd0;

        @(negedge clk);
        dir = d; dev_addr = dbase; mem_addr = mbase; win_bytes = WIN_W'(w);
        elem_log2 = 2'(el); elems_per_frame = CNT_W'(en); frame_count = CNT_W'(fn);
        start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        // scramble configuration inputs: latched copy must be used (R2)
        dev_addr = 32'hDEAD_BEEF; mem_addr = 32'h0BAD_F00D; win_bytes = WIN_W'(7);
        #1;
        chk(busy && out_valid, "R2 busy/valid after start", {30'd0, busy, out_valid}, 32'd3);
        chk(src_burst == (d ? 2'd3 : exp_burst(w)), "R7 src_burst", 32'(src_burst),
            32'(d ? 2'd3 : exp_burst(w)));
        chk(dst_burst == (d ? exp_burst(w) : 2'd3), "R7 dst_burst", 32'(dst_burst),
            32'(d ? exp_burst(w) : 2'd3));
        chk(post_mode == epost, "R8 post_mode", 32'(post_mode), 32'(epost));

        k = 0; e = 0; f = 0;
        forever begin
            out_ready = ((cyc % 3) != 2);
            if (cyc % 7 == 3) start = 1'b1;   // ignored while busy (R2)
            #1;
            edev  = (w != 0) ? dbase + 32'(e * esz) : dbase;
            emem  = mbase + 32'(k * esz);
            esrc  = d ? emem : edev;
            edst  = d ? edev : emem;
            flast = (e == en_e - 1);
            elast = flast && (f == fn_e - 1);
            enp   = (epost == 2'd0) ? 1'b1 : elast;
            chk(out_valid, "R2 valid during transfer", 32'(out_valid), 32'd1);
            chk(src_addr == esrc, out_ready ? (w != 0 && !d ? "R5 src addr" : "R6 src addr")
                                            : "R11 src addr held", src_addr, esrc);
            chk(dst_addr == edst, out_ready ? (d ? "R4 dst addr" : "R4 dst addr mem")
                                            : "R11 dst addr held", dst_addr, edst);
            if (w == 0)
                chk((d ? dst_addr : src_addr) == dbase, "R3 constant device addr",
                    d ? dst_addr : src_addr, dbase);
            chk(frame_last == flast, "R9 frame_last", 32'(frame_last), 32'(flast));
            chk(xfer_last == elast, "R9 xfer_last", 32'(xfer_last), 32'(elast));
            chk(write_nonposted == enp, "R8 write_nonposted", 32'(write_nonposted), 32'(enp));
            if (out_ready) begin
                k++;
                if (flast) begin e = 0; f++; end else e++;
                if (elast) break;
            end
            @(negedge clk);
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done && !busy && !out_valid, "R10 done pulse / idle",
            {29'd0, done, busy, out_valid}, 32'd4);
        chk(k == en_e * fn_e, "R9 handshake count", 32'(k), 32'(en_e * fn_e));
        @(negedge clk);
        #1;
        chk(!done, "R10 done one cycle", 32'(done), 32'd0);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int wins [5] = '{0, 16, 48, 64, 8};
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !out_valid && !done, "R1 reset state",
            {29'd0, busy, out_valid, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!busy && !out_valid && !done, "R1 idle after reset",
            {29'd0, busy, out_valid, done}, 32'd0);
        for (int d = 0; d < 2; d++) begin
            for (int wi = 0; wi < 5; wi++) begin
                for (int el = 0; el < 3; el++) begin
                    int w = wins[wi];
                    int en = (w == 0) ? 3 : (w >> el);
                    run_case(d[0], w, el, en, 3);
                end
            end
        end
        // zero counts behave as one element, one frame (R9)
        run_case(1'b0, 0, 2, 0, 0);
        run_case(1'b1, 64, 0, 64, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule